// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the 16-bit operand address for an 8-bit processor core. The decoder hands it four things: an addressing-mode code, the instruction class, the operand bytes that follow the opcode, and the current values of the H:X index pair and the stack pointer. One cycle later the block returns the effective address with a valid strobe. The supported modes are:

- absolute (extended) addressing;
- H:X-based addressing with no offset, an unsigned 8-bit offset, or a 16-bit offset;
- two post-increment forms;
- stack-pointer-based addressing with an 8-bit or 16-bit offset.

For the post-increment forms, the block holds the incremented H:X value until the memory side reports that the operand fetch is complete. Only then does it return that value on a one-cycle write-back port. The fetch therefore always uses the index value from before the increment.

Requests that the block cannot serve raise a one-cycle illegal flag, and no address or write-back is produced. A request cannot be served when its mode code is unknown, or when a post-increment form comes from an instruction class that may not use it. All address arithmetic wraps within 16 bits.

Top module: `idx_ea_gen`

## Requirements
- R1: Mode code 0 (absolute) yields the address {opnd_b0, opnd_b1}. The first byte after the opcode is the high byte.
- R2: Mode code 1 (index only) and mode code 2 (index with post-increment) yield the address hx_in unchanged.
- R3: Mode code 3 (index plus byte) and mode code 4 (index plus byte with post-increment) yield hx_in plus opnd_b0, with opnd_b0 zero-extended.
- R4: Mode code 5 (index plus word) yields hx_in plus {opnd_b0, opnd_b1}.
- R5: Mode code 6 yields sp_in plus zero-extended opnd_b0. Mode code 7 yields sp_in plus {opnd_b0, opnd_b1}.
- R6: Every address sum, and the H:X increment, wraps modulo 2^16, so 0xFFFF + 1 gives 0x0000.
- R7: A legal request sampled with req_vld high produces ea_vld high for exactly the next cycle, with ea_out valid in that cycle. No ea_vld appears without a request.
- R8: For a legal post-increment request, hx_wr_en pulses for one cycle, with hx_wr_data equal to the captured hx_in plus 1. The pulse comes in the cycle after fetch_done is sampled high while a write-back is pending. The earliest such sample is the ea_vld cycle. fetch_done with nothing pending has no effect.
- R9: Mode codes 8 to 15 raise illegal for one cycle, in the cycle after the request. They produce neither ea_vld nor a write-back.
- R10: The instruction-class encoding is: 0 general, 1 move, 2 compare-and-branch, 3 treated as general. Mode code 2 requires class 1 or 2, and mode code 4 requires class 2. Any other pairing is illegal (as in R9), and it leaves a write-back that is already pending untouched.
- R11: When fetch_done for a pending write-back and a new post-increment request fall in the same cycle, both happen. The write-back carries the older value, and the new request arms a fresh pending write-back.
- R12: During and just after reset, ea_vld, illegal and hx_wr_en are low and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Address request this cycle |
| mode_code | input | 4 | Addressing-mode code (see R1 to R5, R9) |
| ins_class | input | 2 | Instruction class (see R10) |
| opnd_b0 | input | 8 | First operand byte after the opcode |
| opnd_b1 | input | 8 | Second operand byte after the opcode |
| hx_in | input | 16 | Current H:X index pair |
| sp_in | input | 16 | Current stack pointer |
| fetch_done | input | 1 | Operand fetch complete |
| ea_out | output | 16 | Effective address |
| ea_vld | output | 1 | Effective address valid |
| illegal | output | 1 | Request rejected |
| hx_wr_data | output | 16 | Incremented H:X for write-back |
| hx_wr_en | output | 1 | H:X write-back strobe |

## Verification
Two of the block's functions can fall in the same cycle: the write-back that completes one post-increment access, and the capture of the next post-increment request. To provoke this, the bench drives fetch_done for a pending H:X of 0x00FF in the same cycle as a new offset post-increment request with H:X 0xFFFF. In the following cycle it expects write-back data 0x0100 alongside ea_out 0x0001. It then finishes the second access and expects the wrapped write-back 0x0000. It also checks that an illegal request arriving between arming and fetch completion leaves the pending value intact.

// File: rtl/ea_pkg.sv
package ea_pkg;

   localparam int MODE_W  = 4;
   localparam int CLASS_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MD_ABS   = 4'd0,
      MD_IX    = 4'd1,
      MD_IXP   = 4'd2,
      MD_IXB   = 4'd3,
      MD_IXBP  = 4'd4,
      MD_IXW   = 4'd5,
      MD_SPB   = 4'd6,
      MD_SPW   = 4'd7
   } ea_mode_e;

   typedef enum logic [CLASS_W-1:0] {
      CL_GEN = 2'd0,
      CL_MOV = 2'd1,
      CL_CBR = 2'd2,
      CL_RSV = 2'd3
   } ea_class_e;

   typedef enum logic [1:0] {
      BS_ZERO = 2'd0,
      BS_HX   = 2'd1,
      BS_SP   = 2'd2
   } ea_base_e;

   typedef enum logic [1:0] {
      OF_NONE = 2'd0,
      OF_BYTE = 2'd1,
      OF_WORD = 2'd2
   } ea_off_e;

endpackage

// File: rtl/ea_mode_chk.sv
module ea_mode_chk
   import ea_pkg::*;
#(
   parameter bit SP_MODES_EN = 1'b1
) (
   input  logic [MODE_W-1:0]  mode,
   input  logic [CLASS_W-1:0] cls,
   output logic               legal,
   output logic               is_post,
   output ea_base_e           base_sel,
   output ea_off_e            off_sel
);

   logic sp_ok;
   logic known;
   logic cls_ok;

   generate
      if (SP_MODES_EN) begin : g_sp_on
         assign sp_ok = 1'b1;
      end else begin : g_sp_off
         assign sp_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      known    = 1'b1;
      is_post  = 1'b0;
      cls_ok   = 1'b1;
      base_sel = BS_ZERO;
      off_sel  = OF_NONE;
      case (mode)
         MD_ABS: begin
            off_sel = OF_WORD;
         end
         MD_IX: begin
            base_sel = BS_HX;
         end
         MD_IXP: begin
            base_sel = BS_HX;
            is_post  = 1'b1;
            cls_ok   = (cls == CL_MOV) || (cls == CL_CBR);
         end
         MD_IXB: begin
            base_sel = BS_HX;
            off_sel  = OF_BYTE;
         end
         MD_IXBP: begin
            base_sel = BS_HX;
            off_sel  = OF_BYTE;
            is_post  = 1'b1;
            cls_ok   = (cls == CL_CBR);
         end
         MD_IXW: begin
            base_sel = BS_HX;
            off_sel  = OF_WORD;
         end
         MD_SPB: begin
            base_sel = BS_SP;
            off_sel  = OF_BYTE;
            known    = sp_ok;
         end
         MD_SPW: begin
            base_sel = BS_SP;
            off_sel  = OF_WORD;
            known    = sp_ok;
         end
         default: begin
            known = 1'b0;
         end
      endcase
      legal = known && cls_ok;
   end

   // R10
   always_comb begin
      post_class_chk : assert (!(legal && is_post && cls == CL_GEN))
         else $error("post-increment accepted for general class");
   end

endmodule

// File: rtl/ea_addr_sum.sv
module ea_addr_sum
   import ea_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 16
) (
   input  ea_base_e          base_sel,
   input  ea_off_e           off_sel,
   input  logic [DW-1:0]     b0,
   input  logic [DW-1:0]     b1,
   input  logic [AW-1:0]     hx,
   input  logic [AW-1:0]     sp,
   output logic [AW-1:0]     ea
);

   localparam int WORD_W = 2 * DW;

   logic [AW-1:0] base_v;
   logic [AW-1:0] off_v;
   logic [WORD_W-1:0] word_v;

   assign word_v = {b0, b1};

   always_comb begin
      case (base_sel)
         BS_HX:   base_v = hx;
         BS_SP:   base_v = sp;
         default: base_v = '0;
      endcase
   end

   always_comb begin
      case (off_sel)
         OF_BYTE: off_v = AW'(b0);
         OF_WORD: off_v = AW'(word_v);
         default: off_v = '0;
      endcase
   end

   assign ea = base_v + off_v;

endmodule

// File: rtl/ea_postinc_trk.sv
module ea_postinc_trk #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic [AW-1:0] hx,
   input  logic          fetch_done,
   output logic          wr_en,
   output logic [AW-1:0] wr_data
);

   logic          pend_q;
   logic [AW-1:0] hold_q;
   logic          fire;

   assign fire = pend_q && fetch_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         hold_q  <= '0;
         wr_en   <= 1'b0;
         wr_data <= '0;
      end else begin
         wr_en <= fire;
         if (fire) begin
            wr_data <= hold_q;
         end
         if (arm) begin
            pend_q <= 1'b1;
            hold_q <= hx + AW'(1);
         end else if (fire) begin
            pend_q <= 1'b0;
         end
      end
   end

   // R8
   wb_cause_chk : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(fetch_done))
      else $error("write-back without fetch completion");

   // R8
   wb_clear_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !arm) |=> !pend_q)
      else $error("pending flag not cleared after write-back");

endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
   import ea_pkg::*;
#(
   parameter int DW          = 8,
   parameter int AW          = 16,
   parameter bit SP_MODES_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_vld,
   input  logic [3:0]    mode_code,
   input  logic [1:0]    ins_class,
   input  logic [DW-1:0] opnd_b0,
   input  logic [DW-1:0] opnd_b1,
   input  logic [AW-1:0] hx_in,
   input  logic [AW-1:0] sp_in,
   input  logic          fetch_done,
   output logic [AW-1:0] ea_out,
   output logic          ea_vld,
   output logic          illegal,
   output logic [AW-1:0] hx_wr_data,
   output logic          hx_wr_en
);

   initial begin
      aw_fit_chk : assert (AW == 2 * DW)
         else $error("address width must be twice the data width");
   end

   logic          legal;
   logic          is_post;
   ea_base_e      base_sel;
   ea_off_e       off_sel;
   logic [AW-1:0] ea_comb;
   logic          arm;

   ea_mode_chk #(
      .SP_MODES_EN (SP_MODES_EN)
   ) u_mode (
      .mode     (mode_code),
      .cls      (ins_class),
      .legal    (legal),
      .is_post  (is_post),
      .base_sel (base_sel),
      .off_sel  (off_sel)
   );

   ea_addr_sum #(
      .DW (DW),
      .AW (AW)
   ) u_sum (
      .base_sel (base_sel),
      .off_sel  (off_sel),
      .b0       (opnd_b0),
      .b1       (opnd_b1),
      .hx       (hx_in),
      .sp       (sp_in),
      .ea       (ea_comb)
   );

   assign arm = req_vld && legal && is_post;

   ea_postinc_trk #(
      .AW (AW)
   ) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .hx         (hx_in),
      .fetch_done (fetch_done),
      .wr_en      (hx_wr_en),
      .wr_data    (hx_wr_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_out  <= '0;
         ea_vld  <= 1'b0;
         illegal <= 1'b0;
      end else begin
         ea_vld  <= req_vld && legal;
         illegal <= req_vld && !legal;
         if (req_vld && legal) begin
            ea_out <= ea_comb;
         end
      end
   end

   // R9
   vld_ill_excl_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !(ea_vld && illegal))
      else $error("valid and illegal together");

   // R7
   vld_cause_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (ea_vld || illegal) |-> $past(req_vld))
      else $error("response without request");

   // R2
   ix_addr_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (ea_vld && $past(mode_code) == MD_IX) |-> ea_out == $past(hx_in))
      else $error("index-only address mismatch");

   // R9
   bad_code_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && mode_code[3]) |=> (illegal && !ea_vld))
      else $error("unknown mode code not rejected");

endmodule

// File: tb/idx_ea_gen_tb.sv
module idx_ea_gen_tb;
   import ea_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [3:0]  mode_code = '0;
   logic [1:0]  ins_class = '0;
   logic [7:0]  opnd_b0 = '0;
   logic [7:0]  opnd_b1 = '0;
   logic [15:0] hx_in = '0;
   logic [15:0] sp_in = '0;
   logic        fetch_done = 1'b0;
   logic [15:0] ea_out;
   logic        ea_vld;
   logic        illegal;
   logic [15:0] hx_wr_data;
   logic        hx_wr_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   idx_ea_gen u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_vld    (req_vld),
      .mode_code  (mode_code),
      .ins_class  (ins_class),
      .opnd_b0    (opnd_b0),
      .opnd_b1    (opnd_b1),
      .hx_in      (hx_in),
      .sp_in      (sp_in),
      .fetch_done (fetch_done),
      .ea_out     (ea_out),
      .ea_vld     (ea_vld),
      .illegal    (illegal),
      .hx_wr_data (hx_wr_data),
      .hx_wr_en   (hx_wr_en)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // drive one request cycle; returns at the negedge of the response cycle
   task automatic issue(input logic [3:0] m, input logic [1:0] c,
                        input logic [7:0] b0, input logic [7:0] b1,
                        input logic [15:0] hx, input logic [15:0] sp,
                        input logic fd);
      req_vld    = 1'b1;
      mode_code  = m;
      ins_class  = c;
      opnd_b0    = b0;
      opnd_b1    = b1;
      hx_in      = hx;
      sp_in      = sp;
      fetch_done = fd;
      @(negedge clk);
      req_vld    = 1'b0;
      fetch_done = 1'b0;
   endtask

   task automatic pulse_fetch();
      fetch_done = 1'b1;
      @(negedge clk);
      fetch_done = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R12 ea_vld", ea_vld, 0);
      chk("R12 illegal", illegal, 0);
      chk("R12 hx_wr_en", hx_wr_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      pulse_fetch();
      chk("R12 nothing pending after reset", hx_wr_en, 0);
   endtask

   task automatic t_abs();
      issue(MD_ABS, CL_GEN, 8'hA5, 8'h3C, 16'h1111, 16'h2222, 0);
      chk("R1 absolute addr", ea_out, 16'hA53C);
      chk("R7 valid strobe", ea_vld, 1);
      @(negedge clk);
      chk("R7 valid one cycle", ea_vld, 0);
   endtask

   task automatic t_index();
      issue(MD_IX, CL_GEN, 8'h55, 8'h66, 16'h4321, 16'h0000, 0);
      chk("R2 index only", ea_out, 16'h4321);
      issue(MD_IXP, CL_MOV, 8'h55, 8'h66, 16'h8001, 16'h0000, 0);
      chk("R2 index post-inc addr", ea_out, 16'h8001);
      chk("R2 no early write-back", hx_wr_en, 0);
      pulse_fetch();
      chk("R8 write-back strobe", hx_wr_en, 1);
      chk("R8 write-back data", hx_wr_data, 16'h8002);
      @(negedge clk);
      chk("R8 write-back one cycle", hx_wr_en, 0);
   endtask

   task automatic t_byte_off();
      issue(MD_IXB, CL_GEN, 8'hF0, 8'h00, 16'h0100, 16'h0000, 0);
      chk("R3 byte offset zero-extended", ea_out, 16'h01F0);
      issue(MD_IXBP, CL_CBR, 8'h80, 8'h00, 16'h2000, 16'h0000, 0);
      chk("R3 byte offset post-inc addr", ea_out, 16'h2080);
      pulse_fetch();
      chk("R8 byte post-inc data", hx_wr_data, 16'h2001);
   endtask

   task automatic t_word_off();
      issue(MD_IXW, CL_GEN, 8'h12, 8'h34, 16'h1000, 16'h0000, 0);
      chk("R4 word offset", ea_out, 16'h2234);
   endtask

   task automatic t_stack();
      issue(MD_SPB, CL_GEN, 8'hFF, 8'h77, 16'h0000, 16'h01F0, 0);
      chk("R5 stack byte offset", ea_out, 16'h02EF);
      issue(MD_SPW, CL_GEN, 8'h01, 8'h02, 16'h0000, 16'h0F00, 0);
      chk("R5 stack word offset", ea_out, 16'h1002);
   endtask

   task automatic t_wrap();
      issue(MD_IXW, CL_GEN, 8'hFF, 8'hFF, 16'h0002, 16'h0000, 0);
      chk("R6 word wrap", ea_out, 16'h0001);
      issue(MD_SPB, CL_GEN, 8'h10, 8'h00, 16'h0000, 16'hFFF8, 0);
      chk("R6 stack wrap", ea_out, 16'h0008);
   endtask

   task automatic t_bad_code();
      issue(4'd9, CL_GEN, 8'h00, 8'h00, 16'h1234, 16'h0000, 0);
      chk("R9 illegal flag", illegal, 1);
      chk("R9 no valid", ea_vld, 0);
      @(negedge clk);
      chk("R9 illegal one cycle", illegal, 0);
      issue(4'd15, CL_CBR, 8'h00, 8'h00, 16'h1234, 16'h0000, 0);
      chk("R9 code 15 illegal", illegal, 1);
      pulse_fetch();
      chk("R9 no write-back", hx_wr_en, 0);
   endtask

   task automatic t_class();
      issue(MD_IXP, CL_GEN, 8'h00, 8'h00, 16'h3000, 16'h0000, 0);
      chk("R10 post-inc general illegal", illegal, 1);
      chk("R10 post-inc general no valid", ea_vld, 0);
      pulse_fetch();
      chk("R10 no write-back", hx_wr_en, 0);
      issue(MD_IXP, CL_CBR, 8'h00, 8'h00, 16'h4000, 16'h0000, 0);
      chk("R10 post-inc compare ok", ea_vld, 1);
      issue(MD_IXBP, CL_MOV, 8'h05, 8'h00, 16'h9999, 16'h0000, 0);
      chk("R10 byte post-inc move illegal", illegal, 1);
      pulse_fetch();
      chk("R10 pending kept strobe", hx_wr_en, 1);
      chk("R10 pending kept data", hx_wr_data, 16'h4001);
      issue(MD_IXBP, CL_RSV, 8'h05, 8'h00, 16'h9999, 16'h0000, 0);
      chk("R10 class 3 as general", illegal, 1);
   endtask

   task automatic t_overlap();
      issue(MD_IXP, CL_MOV, 8'h00, 8'h00, 16'h00FF, 16'h0000, 0);
      chk("R11 first addr", ea_out, 16'h00FF);
      issue(MD_IXBP, CL_CBR, 8'h02, 8'h00, 16'hFFFF, 16'h0000, 1);
      chk("R11 old write-back strobe", hx_wr_en, 1);
      chk("R11 old write-back data", hx_wr_data, 16'h0100);
      chk("R11 new valid", ea_vld, 1);
      chk("R11 new addr", ea_out, 16'h0001);
      pulse_fetch();
      chk("R11 new write-back strobe", hx_wr_en, 1);
      chk("R6 increment wraps", hx_wr_data, 16'h0000);
   endtask

   initial begin
      t_reset();
      t_abs();
      t_index();
      t_byte_off();
      t_word_off();
      t_stack();
      t_wrap();
      t_bad_code();
      t_class();
      t_overlap();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule